// File: doc/BRIEF.md
# Reconfigurable Boot Memory-Map Decoder

This block is the chip-select decoder placed between an 8-bit microcontroller with separate program and data address spaces and its memories. Each cycle it looks at a demultiplexed 16-bit address and three active-high strobes: opcode fetch, data read and data write. It then asserts at most one select among eight main flash sectors (16 KB each), four secondary flash sectors (8 KB each), a 2 KB SRAM, a 256-byte control-register window and a 256-byte peripheral window. Accesses that land nowhere raise an unmapped flag.

The map is not fixed. Software changes it at runtime by writing through the control window. A space-mapping byte decides which flash array shows up in which address space. A page field picks one of four main-flash pages. Two mode bits, swap and unlock, change the layout further. With swap set, the first two main sectors take over the low program area, so firmware can hand execution from boot flash to main flash at the same address with one write. A later mapping write can move the secondary flash into data space so it can be rewritten. The unlock bit then decides which half of that flash accepts writes.

Register writes are taken once per write strobe. A small two-state controller does this: WR_IDLE moves to WR_HELD when the write strobe rises, and the register load happens on that transition only. WR_HELD returns to WR_IDLE once the strobe drops. The new map applies from the next cycle on.

Top module: `boot_map_decoder`

## Requirements
- R1: After reset the mapping byte reads 12h and the mode register reads 00h (page 0, swap 0, unlock 0).
- R2: With no strobe, no select, no unmapped flag and no write-enable are active. A cycle with fetch high is decoded as a program access only, even if rd or wr is also high; such a cycle never loads a register. Otherwise rd or wr selects data-space decoding.
- R3: In data space the block decodes three fixed windows: 0200h-02FFh asserts ctrl_sel, 0300h-03FFh asserts periph_sel and 2000h-27FFh asserts sram_sel. Data addresses 0000h-01FFh, 0400h-1FFFh and 2800h-7FFFh are unmapped.
- R4: Mapping bit 1 places the secondary flash in program space. With swap 0 the layout is boot_sel[0] at 0000h-1FFFh, [1] at 2000h-3FFFh, [2] at C000h-DFFFh and [3] at E000h-FFFFh.
- R5: Main flash is paged. For page p (mode bits [1:0]), addresses 8000h-BFFFh select main_sel[2p] and C000h-FFFFh select main_sel[2p+1]. Main flash appears in program space when mapping bit 2 is set. It appears in data space when bit 4 or bit 2 is set. In program space with swap 0, boot sectors win the C000h-FFFFh overlap.
- R6: With swap 1 (mode bit 2) and mapping bit 2 set, program 0000h-3FFFh selects main_sel[0] and 4000h-7FFFh selects main_sel[1] in every page. With mapping bit 1 set, program 8000h-FFFFh shows boot sectors 0..3 in 8 KB steps. Otherwise that range shows paged main flash for pages 1-3 and is unmapped for page 0.
- R7: A write that sets swap takes effect for the very next fetch cycle.
- R8: Mapping bit 3 maps the secondary flash into data space at 8000h-FFFFh as sectors 0..3 in 8 KB steps. There it takes precedence over main flash.
- R9: boot_we is high only on a data write that selects a secondary sector in data space whose index bit 1 equals the unlock bit (mode bit 3). So unlock 0 opens sectors 0-1 and unlock 1 opens sectors 2-3.
- R10: A data write to control offset 00h loads the mapping byte. Offset 01h loads the mode register (bits [1:0] page, bit 2 swap, bit 3 unlock). A data read in the window returns these values, with zero in the unused mode bits and zero at every other offset. rdata is zero outside a control-window read.
- R11: At most one select is active per cycle. unmapped is high exactly when a strobe is active and no select is.
- R12: Holding wr over several cycles loads a register once, with the data present in the first cycle. Later data changes in that same strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Demultiplexed address |
| wdata | input | 8 | Write data for the control window |
| fetch | input | 1 | Opcode fetch strobe (program space) |
| rd | input | 1 | Data read strobe |
| wr | input | 1 | Data write strobe |
| main_sel | output | 8 | One-hot main flash sector select |
| boot_sel | output | 4 | One-hot secondary flash sector select |
| sram_sel | output | 1 | SRAM select |
| ctrl_sel | output | 1 | Control-register window select |
| periph_sel | output | 1 | Peripheral select |
| unmapped | output | 1 | Strobed access that hits no region |
| boot_we | output | 1 | Write enable for the secondary flash |
| rdata | output | 8 | Control-register read data |

## Verification
The bench walks the four-stage boot sequence: reset map, mapping 06h, swap set, mapping 0Ch. At every stage and in every page it sweeps region edges in both spaces. A design that let main flash win the C000h overlap would fetch the wrong code after the first remap. One that delayed swap by a cycle would run the instruction after the swap write out of boot flash. The bench also holds a write strobe while changing the data, to expose a level-sensitive load that would take the last value instead of the first. It asserts fetch together with a write into the control window, where a design that let the write through would change the map. It also writes secondary sectors under both unlock values, where a swapped half would enable the wrong sectors.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int MAIN_N  = 8;
    localparam int BOOT_N  = 4;
    localparam int PAGE_W  = 2;
    localparam int MIDX_W  = PAGE_W + 1;
    localparam int BIDX_W  = $clog2(BOOT_N);

    // mapping byte bit positions
    localparam int MAP_BOOT_PROG = 1;
    localparam int MAP_MAIN_PROG = 2;
    localparam int MAP_BOOT_DATA = 3;
    localparam int MAP_MAIN_DATA = 4;
    localparam logic [DATA_W-1:0] MAP_RESET = 8'h12;

    // window bases (upper address byte)
    localparam logic [7:0] CTRL_PAGE   = 8'h02;
    localparam logic [7:0] PERIPH_PAGE = 8'h03;
    localparam logic [4:0] SRAM_TOP5   = 5'b00100;

    // control offsets
    localparam logic [7:0] OFF_MAP  = 8'h00;
    localparam logic [7:0] OFF_MODE = 8'h01;

    typedef enum logic {
        WR_IDLE,
        WR_HELD
    } wr_state_e;

    typedef struct packed {
        logic [MAIN_N-1:0] main;
        logic [BOOT_N-1:0] boot;
        logic              sram;
        logic              ctrl;
        logic              periph;
    } sel_t;

endpackage

// File: rtl/bmd_ctrl_regs.sv
module bmd_ctrl_regs
    import bmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                dwr,
    input  logic                drd,
    output logic [DATA_W-1:0]   map_q,
    output logic [PAGE_W-1:0]   page_q,
    output logic                swap_q,
    output logic                unlock_q,
    output logic [DATA_W-1:0]   rdata
);

    localparam int PAD_W = DATA_W - PAGE_W - 2;

    wr_state_e state_q, state_d;
    logic      ctrl_hit;
    logic      load_en;

    assign ctrl_hit = (addr[15:8] == CTRL_PAGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        unique case (state_q)
            WR_IDLE: begin
                if (dwr) begin
                    state_d = WR_HELD;
                    load_en = ctrl_hit;
                end
            end
            WR_HELD: begin
                if (!dwr) state_d = WR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q    <= MAP_RESET;
            page_q   <= '0;
            swap_q   <= 1'b0;
            unlock_q <= 1'b0;
        end else if (load_en) begin
            if (addr[7:0] == OFF_MAP) begin
                map_q <= wdata;
            end else if (addr[7:0] == OFF_MODE) begin
                page_q   <= wdata[PAGE_W-1:0];
                swap_q   <= wdata[PAGE_W];
                unlock_q <= wdata[PAGE_W+1];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (drd && ctrl_hit) begin
            if (addr[7:0] == OFF_MAP)
                rdata = map_q;
            else if (addr[7:0] == OFF_MODE)
                rdata = {{PAD_W{1'b0}}, unlock_q, swap_q, page_q};
        end
    end

    AST_MAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_IDLE && dwr && ctrl_hit && addr[7:0] == OFF_MAP)
        |=> (map_q == $past(wdata))); // R10

    AST_HELD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_HELD)
        |=> ($stable(map_q) && $stable(page_q) && $stable(swap_q) && $stable(unlock_q))); // R12

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!drd) |-> (rdata == '0)); // R10

endmodule

// File: rtl/bmd_prog_decode.sv
module bmd_prog_decode
    import bmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   map_q,
    input  logic [PAGE_W-1:0]   page_q,
    input  logic                swap_q,
    output sel_t                sel
);

    logic              boot_p, main_p;
    logic              main_hit, boot_hit;
    logic [MIDX_W-1:0] main_idx;
    logic [BIDX_W-1:0] boot_idx;

    assign boot_p = map_q[MAP_BOOT_PROG];
    assign main_p = map_q[MAP_MAIN_PROG];

    always_comb begin
        main_hit = 1'b0;
        boot_hit = 1'b0;
        main_idx = '0;
        boot_idx = '0;
        if (en) begin
            if (!swap_q) begin
                if (boot_p && addr[15:14] == 2'b00) begin
                    boot_hit = 1'b1;
                    boot_idx = {1'b0, addr[13]};
                end else if (boot_p && addr[15:14] == 2'b11) begin
                    boot_hit = 1'b1;
                    boot_idx = {1'b1, addr[13]};
                end else if (main_p && addr[15]) begin
                    main_hit = 1'b1;
                    main_idx = {page_q, addr[14]};
                end
            end else begin
                if (!addr[15]) begin
                    if (main_p) begin
                        main_hit = 1'b1;
                        main_idx = {{PAGE_W{1'b0}}, addr[14]};
                    end
                end else if (boot_p) begin
                    boot_hit = 1'b1;
                    boot_idx = addr[14:13];
                end else if (main_p && page_q != '0) begin
                    main_hit = 1'b1;
                    main_idx = {page_q, addr[14]};
                end
            end
        end
    end

    for (genvar gi = 0; gi < MAIN_N; gi++) begin : g_main
        assign sel.main[gi] = main_hit && (main_idx == MIDX_W'(gi));
    end
    for (genvar gb = 0; gb < BOOT_N; gb++) begin : g_boot
        assign sel.boot[gb] = boot_hit && (boot_idx == BIDX_W'(gb));
    end
    assign sel.sram   = 1'b0;
    assign sel.ctrl   = 1'b0;
    assign sel.periph = 1'b0;

    AST_SWAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && swap_q && main_p && !addr[15])
        |-> (sel.main[0] != sel.main[1]) && (sel.boot == '0)); // R6

    AST_BOOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !swap_q && boot_p && addr[15:14] == 2'b11)
        |-> (sel.main == '0)); // R5

endmodule

// File: rtl/bmd_data_decode.sv
module bmd_data_decode
    import bmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                dwr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   map_q,
    input  logic [PAGE_W-1:0]   page_q,
    input  logic                unlock_q,
    output sel_t                sel,
    output logic                boot_we
);

    logic              boot_d, main_d;
    logic              main_hit, boot_hit;
    logic [MIDX_W-1:0] main_idx;
    logic [BIDX_W-1:0] boot_idx;

    assign boot_d = map_q[MAP_BOOT_DATA];
    assign main_d = map_q[MAP_MAIN_DATA] | map_q[MAP_MAIN_PROG];

    always_comb begin
        main_hit = 1'b0;
        boot_hit = 1'b0;
        main_idx = '0;
        boot_idx = '0;
        if (en && addr[15]) begin
            if (boot_d) begin
                boot_hit = 1'b1;
                boot_idx = addr[14:13];
            end else if (main_d) begin
                main_hit = 1'b1;
                main_idx = {page_q, addr[14]};
            end
        end
    end

    for (genvar gi = 0; gi < MAIN_N; gi++) begin : g_main
        assign sel.main[gi] = main_hit && (main_idx == MIDX_W'(gi));
    end
    for (genvar gb = 0; gb < BOOT_N; gb++) begin : g_boot
        assign sel.boot[gb] = boot_hit && (boot_idx == BIDX_W'(gb));
    end

    assign sel.ctrl   = en && (addr[15:8] == CTRL_PAGE);
    assign sel.periph = en && (addr[15:8] == PERIPH_PAGE);
    assign sel.sram   = en && (addr[15:11] == SRAM_TOP5);

    assign boot_we = dwr && boot_hit && (boot_idx[BIDX_W-1] == unlock_q);

    AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        boot_we |-> (dwr && en && $onehot(sel.boot))); // R9

endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
    import bmd_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [15:0]  addr,
    input  logic [7:0]   wdata,
    input  logic         fetch,
    input  logic         rd,
    input  logic         wr,
    output logic [7:0]   main_sel,
    output logic [3:0]   boot_sel,
    output logic         sram_sel,
    output logic         ctrl_sel,
    output logic         periph_sel,
    output logic         unmapped,
    output logic         boot_we,
    output logic [7:0]   rdata
);

    logic              drd, dwr, data_en, any_strobe;
    logic [DATA_W-1:0] map_q;
    logic [PAGE_W-1:0] page_q;
    logic              swap_q, unlock_q;
    sel_t              prog_sel, data_sel, sel;
    logic              data_we;

    assign drd        = rd & ~fetch;
    assign dwr        = wr & ~fetch;
    assign data_en    = drd | dwr;
    assign any_strobe = fetch | rd | wr;

    bmd_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .dwr      (dwr),
        .drd      (drd),
        .map_q    (map_q),
        .page_q   (page_q),
        .swap_q   (swap_q),
        .unlock_q (unlock_q),
        .rdata    (rdata)
    );

    bmd_prog_decode u_prog (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (fetch),
        .addr   (addr),
        .map_q  (map_q),
        .page_q (page_q),
        .swap_q (swap_q),
        .sel    (prog_sel)
    );

    bmd_data_decode u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (data_en),
        .dwr      (dwr),
        .addr     (addr),
        .map_q    (map_q),
        .page_q   (page_q),
        .unlock_q (unlock_q),
        .sel      (data_sel),
        .boot_we  (data_we)
    );

    always_comb begin
        sel = fetch ? prog_sel : data_sel;
    end

    assign main_sel   = sel.main;
    assign boot_sel   = sel.boot;
    assign sram_sel   = sel.sram;
    assign ctrl_sel   = sel.ctrl;
    assign periph_sel = sel.periph;
    assign boot_we    = data_we;
    assign unmapped   = any_strobe && (sel == '0);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_sel, boot_sel, sram_sel, ctrl_sel, periph_sel})); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch || rd || wr) |-> ({main_sel, boot_sel, sram_sel, ctrl_sel, periph_sel, unmapped, boot_we} == '0)); // R2

    AST_UNMAPPED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> ({main_sel, boot_sel, sram_sel, ctrl_sel, periph_sel} == '0)); // R11

    AST_FETCH_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> !boot_we && !ctrl_sel && !sram_sel && !periph_sel); // R2

endmodule

// File: tb/boot_map_decoder_tb.sv
module boot_map_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        fetch = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0]  main_sel, rdata;
    logic [3:0]  boot_sel;
    logic        sram_sel, ctrl_sel, periph_sel, unmapped, boot_we;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    int m_map = 'h12;
    int m_page = 0;
    bit m_swap = 0, m_unlock = 0, m_prevw = 0;

    always #10 clk = ~clk;

    boot_map_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .fetch(fetch), .rd(rd), .wr(wr),
        .main_sel(main_sel), .boot_sel(boot_sel), .sram_sel(sram_sel),
        .ctrl_sel(ctrl_sel), .periph_sel(periph_sel), .unmapped(unmapped),
        .boot_we(boot_we), .rdata(rdata)
    );

    function automatic logic [24:0] model(int a, bit f, bit r, bit w);
        int mi = -1, bi = -1;
        bit s = 0, c = 0, p = 0, we = 0, um = 0;
        logic [7:0] mv = '0;
        logic [3:0] bv = '0;
        logic [7:0] rv = '0;
        bit bp = m_map[1], mp = m_map[2], bd = m_map[3];
        bit md = m_map[4] || m_map[2];
        if (f) begin
            if (!m_swap) begin
                if (bp && a < 'h4000) bi = a / 'h2000;
                else if (bp && a >= 'hC000) bi = a / 'h2000 - 4;
                else if (mp && a >= 'h8000) mi = m_page * 2 + (a >= 'hC000 ? 1 : 0);
            end else begin
                if (a < 'h8000) begin
                    if (mp) mi = a / 'h4000;
                end else if (bp) bi = (a - 'h8000) / 'h2000;
                else if (mp && m_page != 0) mi = m_page * 2 + (a >= 'hC000 ? 1 : 0);
            end
        end else if (r || w) begin
            if (a >= 'h0200 && a < 'h0300) c = 1;
            else if (a >= 'h0300 && a < 'h0400) p = 1;
            else if (a >= 'h2000 && a < 'h2800) s = 1;
            else if (a >= 'h8000) begin
                if (bd) bi = (a - 'h8000) / 'h2000;
                else if (md) mi = m_page * 2 + (a >= 'hC000 ? 1 : 0);
            end
            if (w && bi >= 0 && (bi / 2) == int'(m_unlock)) we = 1;
            if (r && c) begin
                if (a == 'h0200) rv = m_map[7:0];
                else if (a == 'h0201) rv = {4'b0, m_unlock, m_swap, 2'(m_page)};
            end
        end
        if (mi >= 0) mv[mi] = 1'b1;
        if (bi >= 0) bv[bi] = 1'b1;
        um = (f || r || w) && mi < 0 && bi < 0 && !s && !c && !p;
        return {mv, bv, s, c, p, um, we, rv};
    endfunction

    task automatic step(input logic [15:0] a, input bit f, input bit r, input bit w,
                        input logic [7:0] d, input string req);
        logic [24:0] exp_v, act_v;
        addr = a; fetch = f; rd = r; wr = w; wdata = d;
        exp_v = model(int'(a), f, r, w);
        @(negedge clk);
        act_v = {main_sel, boot_sel, sram_sel, ctrl_sel, periph_sel, unmapped, boot_we, rdata};
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s addr=%h f=%0b r=%0b w=%0b actual=%h expected=%h",
                     req, a, f, r, w, act_v, exp_v);
        end
        @(posedge clk);
        if (w && !f && !m_prevw && a[15:8] == 8'h02) begin
            if (a[7:0] == 8'h00) m_map = int'(d);
            else if (a[7:0] == 8'h01) begin
                m_page = int'(d[1:0]); m_swap = d[2]; m_unlock = d[3];
            end
        end
        m_prevw = w && !f;
        #1;
    endtask

    task automatic idle_cyc(input string req);
        step(16'h0000, 0, 0, 0, 8'h00, req);
    endtask

    task automatic wreg(input logic [7:0] off, input logic [7:0] v, input string req);
        step({8'h02, off}, 0, 0, 1, v, req);
        idle_cyc(req);
    endtask

    task automatic set_mode(input int pg, input bit sw, input bit ul, input string req);
        wreg(8'h01, {4'b0, ul, sw, 2'(pg)}, req);
    endtask

    localparam int NA = 22;
    logic [15:0] alist [NA] = '{16'h0000, 16'h01FF, 16'h0200, 16'h02FF, 16'h0300, 16'h03FF,
        16'h0400, 16'h1FFF, 16'h2000, 16'h27FF, 16'h2800, 16'h3FFF, 16'h4000, 16'h7FFF,
        16'h8000, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000, 16'hDFFF, 16'hE000, 16'hFFFF};

    task automatic sweep(input string req);
        for (int pg = 0; pg < 4; pg++) begin
            set_mode(pg, m_swap, m_unlock, "R10");
            for (int i = 0; i < NA; i++) begin
                step(alist[i], 1, 0, 0, 8'h00, req);
                step(alist[i], 0, 1, 0, 8'h00, req);
                if (alist[i][15:8] != 8'h02) begin
                    step(alist[i], 0, 0, 1, 8'hA5, req);
                    idle_cyc(req);
                end
            end
        end
        set_mode(0, m_swap, m_unlock, "R10");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values through readback
        step(16'h0200, 0, 1, 0, 8'h00, "R1");
        step(16'h0201, 0, 1, 0, 8'h00, "R1");
        // R2: no strobe, no select
        step(16'h0000, 0, 0, 0, 8'h00, "R2");
        step(16'h8000, 0, 0, 0, 8'h00, "R2");
        step(16'h2000, 0, 0, 0, 8'h00, "R2");

        // stage 1: reset map (R3 R4 R5)
        sweep("R3 R4 R5 stage1");

        // stage 2: main flash also in program space
        wreg(8'h00, 8'h06, "R10");
        step(16'h0200, 0, 1, 0, 8'h00, "R10");
        sweep("R5 stage2");

        // stage 3: swap, next fetch at once from fs0 (R7)
        step(16'h0201, 0, 0, 1, 8'h04, "R7");
        step(16'h0123, 1, 0, 0, 8'h00, "R7");
        step(16'h0124, 1, 0, 0, 8'h00, "R7");
        idle_cyc("R7");
        sweep("R6 stage3");

        // stage 4: boot flash into data space
        wreg(8'h00, 8'h0C, "R10");
        sweep("R8 R6 stage4");

        // R9: write enable under both unlock values
        for (int u = 0; u < 2; u++) begin
            set_mode(0, 1, u[0], "R9");
            step(16'h8000, 0, 0, 1, 8'h11, "R9");
            idle_cyc("R9");
            step(16'hA123, 0, 0, 1, 8'h11, "R9");
            idle_cyc("R9");
            step(16'hC000, 0, 0, 1, 8'h11, "R9");
            idle_cyc("R9");
            step(16'hFFFF, 0, 0, 1, 8'h11, "R9");
            idle_cyc("R9");
            step(16'hE000, 0, 1, 0, 8'h00, "R9");
        end

        // R2: fetch with a write into the control window loads nothing
        step(16'h0200, 1, 0, 1, 8'h33, "R2");
        idle_cyc("R2");
        step(16'h0200, 0, 1, 0, 8'h00, "R2");
        step(16'h0201, 1, 1, 0, 8'h00, "R2");

        // R12: held strobe loads the first value only
        step(16'h0200, 0, 0, 1, 8'h55, "R12");
        step(16'h0200, 0, 0, 1, 8'h77, "R12");
        step(16'h0200, 0, 0, 1, 8'h99, "R12");
        idle_cyc("R12");
        step(16'h0200, 0, 1, 0, 8'h00, "R12");

        // R10: other offsets read zero, mode high bits read zero
        wreg(8'h05, 8'hFF, "R10");
        step(16'h0205, 0, 1, 0, 8'h00, "R10");
        wreg(8'h01, 8'hFF, "R10");
        step(16'h0201, 0, 1, 0, 8'h00, "R10");
        wreg(8'h00, 8'h12, "R10");
        set_mode(0, 0, 0, "R10");
        step(16'h0000, 1, 0, 0, 8'h00, "R4");

        // R11: unmapped flags
        step(16'h0100, 0, 1, 0, 8'h00, "R11");
        step(16'h5000, 1, 0, 0, 8'h00, "R11");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule